// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous DRAM with multiplexed row and column addresses alive. A prescaler splits the system clock into evenly spaced refresh ticks, so that the whole row space is covered inside the retention window. Each tick adds one refresh to a small backlog. While the backlog is nonzero the block asks the memory controller for the bus. Once it holds the grant, it runs one complete refresh cycle on its own strobe and address outputs, which the controller routes to the DRAM pins while `bus_own` is high.

Two refresh styles are supported, and the style input is sampled when each cycle starts. In the counter-based style, the column strobe falls ahead of the row strobe and the write enable stays high, so the device takes the row from its internal counter. In the row-only style, the column strobe stays high and the block presents a row from its own 10-bit counter. Ticks that arrive while the grant is withheld are kept in a saturating backlog and made up once the grant returns. All strobe widths are clock counts, derived by rounding the nanosecond limits up against the clock period.

Top module: `dram_refresh_sched`

## Requirements
- R1: With the grant held, a refresh request rises once per tick, and successive request rises are exactly TICK_DIV clock cycles apart. TICK_DIV is the refresh interval divided by the clock period, rounded down.
- R2: No strobe cycle starts unless `ref_gnt` and `ref_req` are both high. `ref_req` stays high while any tick remains unserviced.
- R3: The backlog counts unserviced ticks up to 7 and then saturates. After k missed ticks (k ≤ 7), exactly k refresh cycles follow once the grant returns. Beyond 7, further ticks are dropped.
- R4: In the counter-based style (`ras_only_sel`=0), `cas_n` is low for at least one cycle before `ras_n` falls, stays low while `ras_n` is low, and `we_n` is high throughout.
- R5: In the row-only style (`ras_only_sel`=1), `cas_n` stays high. `addr[9:0]` carries the row and `addr[10]` is 0, and the address is stable while `ras_n` is low.
- R6: The row counter is 0 after reset. It advances by one only when a row-only refresh completes, wraps from 1023 to 0, and is left unchanged by counter-based refreshes.
- R7: `ras_n` is low for exactly RAS_CYC cycles in every refresh (4 at the default timing and a 20 ns clock). It is high for at least PRE_CYC cycles (3) before it falls again.
- R8: During and after reset, with nothing pending: `ras_n`, `cas_n` and `we_n` are 1, and `ref_req`, `ref_done` and `bus_own` are 0.
- R9: `ref_done` is a one-cycle pulse, one per completed refresh. `bus_own` is high whenever any strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Controller grants the DRAM bus to the scheduler |
| ras_only_sel | input | 1 | 1 selects row-only refresh, 0 selects counter-based refresh; sampled at cycle start |
| ref_req | output | 1 | Refresh wanted; high while the backlog is nonzero |
| ref_done | output | 1 | One-cycle pulse in the last recovery cycle of a refresh |
| bus_own | output | 1 | Scheduler drives the DRAM strobes and address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low; held high |
| addr | output | 11 | Multiplexed address; row in bits 9:0 for row-only refresh |

## Verification
The assertions assume that once `bus_own` rises, the controller keeps `ref_gnt` high until `ref_done`. They also assume the controller never takes the grant away during a strobe sequence, since the sequence runs to completion regardless. The stimulus changes `ref_gnt` and `ras_only_sel` only at falling clock edges, and only while no refresh is in flight. It times each change against the known tick phase counted from reset, so grants are withdrawn only after the backlog has drained and restored only between ticks. The backlog scenarios deliberately leave the grant low across several ticks to reach saturation. They then keep it high long enough for the whole backlog to drain before the next tick.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_SETUP   = 2'd1,
        SQ_STROBE  = 2'd2,
        SQ_RECOVER = 2'd3
    } seq_state_e;

    typedef enum logic {
        STYLE_CBR      = 1'b0,
        STYLE_ROW_ONLY = 1'b1
    } rfsh_style_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    localparam strobe_t STROBES_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    // Nanoseconds to clock cycles, rounded up, never below one.
    function automatic int unsigned cyc_ceil(int unsigned ns, int unsigned period_ps);
        int unsigned c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        return (c == 0) ? 1 : c;
    endfunction

    // Nanoseconds to clock cycles, rounded down, never below two.
    function automatic int unsigned cyc_floor(int unsigned ns, int unsigned period_ps);
        int unsigned c;
        c = (ns * 1000) / period_ps;
        return (c < 2) ? 2 : c;
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfsh_prescaler.sv
module rfsh_prescaler #(
    parameter int unsigned DIV = 781
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= RELOAD;
        else if (cnt == '0)   cnt <= RELOAD;
        else                  cnt <= cnt - 1'b1;
    end

    assign tick = (cnt == '0);
endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
    parameter int unsigned W = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic done,
    output logic pending
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] owed;

    always_ff @(posedge clk) begin
        if (rst) begin
            owed <= '0;
        end else begin
            unique case ({tick, done})
                2'b10:   if (owed != TOP) owed <= owed + 1'b1;
                2'b01:   if (owed != '0)  owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end

    assign pending = (owed != '0);
endmodule

// File: rtl/rfsh_sequencer.sv
module rfsh_sequencer
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned ROW_BITS = 10,
    parameter int unsigned ADDR_W   = 11,
    parameter int unsigned CSR_CYC  = 1,
    parameter int unsigned RAS_CYC  = 4,
    parameter int unsigned PRE_CYC  = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pending,
    input  logic                gnt,
    input  logic                style_sel,
    output logic                done,
    output logic                own,
    output strobe_t             strb,
    output logic [ADDR_W-1:0]   addr
);
    localparam int unsigned MAXC = umax(CSR_CYC, umax(RAS_CYC, PRE_CYC));
    localparam int unsigned DW_W = $clog2(MAXC + 1);
    localparam logic [DW_W-1:0] LD_CSR = DW_W'(CSR_CYC - 1);
    localparam logic [DW_W-1:0] LD_RAS = DW_W'(RAS_CYC - 1);
    localparam logic [DW_W-1:0] LD_PRE = DW_W'(PRE_CYC - 1);

    seq_state_e          state;
    rfsh_style_e         style;
    logic [DW_W-1:0]     dwell;
    logic [ROW_BITS-1:0] row;
    logic                last;

    assign last = (dwell == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            style <= STYLE_CBR;
            dwell <= '0;
            row   <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: if (pending && gnt) begin
                    state <= SQ_SETUP;
                    dwell <= LD_CSR;
                    style <= rfsh_style_e'(style_sel);
                end
                SQ_SETUP: begin
                    if (last) begin state <= SQ_STROBE; dwell <= LD_RAS; end
                    else      dwell <= dwell - 1'b1;
                end
                SQ_STROBE: begin
                    if (last) begin state <= SQ_RECOVER; dwell <= LD_PRE; end
                    else      dwell <= dwell - 1'b1;
                end
                SQ_RECOVER: begin
                    if (last) begin
                        state <= SQ_IDLE;
                        if (style == STYLE_ROW_ONLY) row <= row + 1'b1;
                    end else begin
                        dwell <= dwell - 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        strb = STROBES_IDLE;
        addr = '0;
        own  = (state != SQ_IDLE);
        if (own && style == STYLE_ROW_ONLY) addr = ADDR_W'(row);
        if (state == SQ_SETUP || state == SQ_STROBE) begin
            if (style == STYLE_CBR) strb.cas_n = 1'b0;
            if (state == SQ_STROBE) strb.ras_n = 1'b0;
        end
    end

    assign done = (state == SQ_RECOVER) && last;
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 20000,
    parameter int unsigned REFRESH_NS    = 15625,
    parameter int unsigned T_RAS_NS      = 70,
    parameter int unsigned T_RP_NS       = 50,
    parameter int unsigned T_RC_NS       = 130,
    parameter int unsigned T_CSR_NS      = 10,
    parameter int unsigned ROW_BITS      = 10,
    parameter int unsigned ADDR_W        = 11,
    parameter int unsigned BACKLOG_W     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_gnt,
    input  logic              ras_only_sel,
    output logic              ref_req,
    output logic              ref_done,
    output logic              bus_own,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr
);
    localparam int unsigned TICK_DIV = cyc_floor(REFRESH_NS, CLK_PERIOD_PS);
    localparam int unsigned CSR_CYC  = cyc_ceil(T_CSR_NS, CLK_PERIOD_PS);
    localparam int unsigned RAS_CYC  = cyc_ceil(T_RAS_NS, CLK_PERIOD_PS);
    localparam int unsigned RC_CYC   = cyc_ceil(T_RC_NS, CLK_PERIOD_PS);
    localparam int unsigned PRE_CYC  = umax(cyc_ceil(T_RP_NS, CLK_PERIOD_PS),
                                            (RC_CYC > RAS_CYC) ? RC_CYC - RAS_CYC : 1);

    logic    tick;
    logic    pending;
    logic    done;
    strobe_t strb;

    rfsh_prescaler #(.DIV(TICK_DIV)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    rfsh_backlog #(.W(BACKLOG_W)) u_backlog (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .done    (done),
        .pending (pending)
    );

    rfsh_sequencer #(
        .ROW_BITS (ROW_BITS),
        .ADDR_W   (ADDR_W),
        .CSR_CYC  (CSR_CYC),
        .RAS_CYC  (RAS_CYC),
        .PRE_CYC  (PRE_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .pending   (pending),
        .gnt       (ref_gnt),
        .style_sel (ras_only_sel),
        .done      (done),
        .own       (bus_own),
        .strb      (strb),
        .addr      (addr)
    );

    assign ref_req  = pending;
    assign ref_done = done;
    assign ras_n    = strb.ras_n;
    assign cas_n    = strb.cas_n;
    assign we_n     = strb.we_n;
endmodule

// File: rtl/dram_refresh_sched_checker.sv
module dram_refresh_sched_checker #(
    parameter int unsigned PRE_CYC = 3,
    parameter int unsigned ADDR_W  = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              ref_req,
    input logic              ref_gnt,
    input logic              ref_done,
    input logic              bus_own,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr
);
    logic [7:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)              hi_cnt <= 8'hFF;
        else if (!ras_n)      hi_cnt <= '0;
        else if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 1'b1;
    end

    assert_cbr_we_high_R4: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && !cas_n) |-> we_n);

    assert_cas_leads_ras_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && !cas_n) |-> ($past(cas_n) == 1'b0));

    assert_top_bit_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && cas_n) |-> (addr[ADDR_W-1] == 1'b0));

    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && $past(!ras_n)) |-> $stable(addr));

    assert_start_needs_grant_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_own) |-> $past(ref_gnt && ref_req));

    assert_precharge_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (hi_cnt >= 8'(PRE_CYC)));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        ref_done |=> !ref_done);

    assert_strobe_owned_R9: assert property (@(posedge clk) disable iff (rst)
        (!ras_n || !cas_n) |-> bus_own);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !bus_own |-> (ras_n && cas_n && we_n));
endmodule

bind dram_refresh_sched dram_refresh_sched_checker #(
    .PRE_CYC (PRE_CYC),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ref_req  (ref_req),
    .ref_gnt  (ref_gnt),
    .ref_done (ref_done),
    .bus_own  (bus_own),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .addr     (addr)
);

// File: tb/dram_refresh_sched_test.sv
`timescale 1ns/1ps
module dram_refresh_sched_test;
    localparam int DIV     = 100;   // 2000 ns interval at 20 ns clock
    localparam int RAS_CYC = 4;
    localparam int PRE_MIN = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gnt = 1'b0;
    logic        sel = 1'b0;
    logic        req, done, own, ras_n, cas_n, we_n;
    logic [10:0] addr;

    dram_refresh_sched #(.CLK_PERIOD_PS(20000), .REFRESH_NS(2000)) uut (
        .clk (clk), .rst (rst), .ref_gnt (gnt), .ras_only_sel (sel),
        .ref_req (req), .ref_done (done), .bus_own (own),
        .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .addr (addr)
    );

    always #10 clk = ~clk;

    int cyc;
    always @(posedge clk) if (rst) cyc <= 0; else cyc <= cyc + 1;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    typedef struct { bit ras_only; int row; } exp_t;
    exp_t sbq[$];
    int   model_row = 0;

    // Driver side: queue the refreshes the requirements predict.
    task automatic push_expect(int n, bit ro);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.ras_only = ro;
            e.row      = model_row;
            sbq.push_back(e);
            if (ro) model_row = (model_row + 1) % 1024;
        end
    endtask

    // Monitor side
    int falls = 0, dones = 0, low_cnt = 0, high_cnt = 0;
    bit prev_ras = 1, prev_cas = 1, prev_done = 0, had_fall = 0;

    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (!ras_n && prev_ras) begin
                falls++;
                if (sbq.size() == 0) begin
                    check(0, "R2 unexpected refresh", falls, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    if (!e.ras_only) begin
                        check(prev_cas == 0, "R4 CAS low before RAS", prev_cas, 0);
                        check(cas_n == 0, "R4 CAS low during RAS", cas_n, 0);
                        check(we_n == 1, "R4 WE held high", we_n, 1);
                    end else begin
                        check(cas_n == 1, "R5 CAS high in row-only", cas_n, 1);
                        check(addr[10] == 1'b0, "R5 addr bit 10 clear", addr[10], 0);
                        check(addr[9:0] == 10'(e.row), "R6 row address", addr[9:0], e.row);
                    end
                end
                if (had_fall) check(high_cnt >= PRE_MIN, "R7 precharge cycles", high_cnt, PRE_MIN);
                had_fall = 1;
            end
            if (ras_n && !prev_ras) begin
                check(low_cnt == RAS_CYC, "R7 RAS low width", low_cnt, RAS_CYC);
                low_cnt = 0;
            end
            if (!ras_n) begin low_cnt++; high_cnt = 0; end
            else        high_cnt++;
            if (done) dones++;
            if (done && prev_done) check(0, "R9 done longer than one cycle", 2, 1);
            if ((!ras_n || !cas_n) && !own) check(0, "R9 strobe without bus_own", own, 1);
            prev_ras  = ras_n;
            prev_cas  = cas_n;
            prev_done = done;
        end
    end

    task automatic wait_phase(int p);
        do @(negedge clk); while ((cyc % DIV) != p);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        int t1, t2, f0, d0;
        gnt = 1'b1;
        sel = 1'b0;
        repeat (4) @(negedge clk);
        check(req == 0, "R8 reset req", req, 0);
        check(ras_n && cas_n && we_n, "R8 reset strobes", {ras_n, cas_n, we_n}, 7);
        check(own == 0 && done == 0, "R8 reset own/done", {own, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(ras_n && cas_n && !own && !req, "R8 quiet after reset", {ras_n, cas_n, own, req}, 4'b1100);

        // R1: tick spacing with counter-based refreshes
        push_expect(2, 1'b0);
        do @(negedge clk); while (!req);
        t1 = cyc;
        check(t1 == DIV, "R1 first tick", t1, DIV);
        do @(negedge clk); while (req);
        do @(negedge clk); while (!req);
        t2 = cyc;
        check(t2 - t1 == DIV, "R1 tick spacing", t2 - t1, DIV);
        wait_phase(50);
        check(sbq.size() == 0, "R1 refreshes serviced", sbq.size(), 0);

        // R2/R3: three missed ticks, then row-only make-up (rows 0..2, R6)
        sel = 1'b1;
        gnt = 1'b0;
        f0 = falls; d0 = dones;
        repeat (3) wait_phase(2);
        check(req == 1, "R2 request held while owed", req, 1);
        check(falls == f0, "R2 no strobe without grant", falls - f0, 0);
        push_expect(3, 1'b1);
        gnt = 1'b1;
        repeat (60) @(negedge clk);
        check(dones - d0 == 3, "R3 three made-up refreshes", dones - d0, 3);
        check(req == 0, "R3 backlog drained", req, 0);

        // R3: ten missed ticks saturate at seven
        gnt = 1'b0;
        f0 = falls; d0 = dones;
        repeat (10) wait_phase(2);
        check(falls == f0, "R2 no strobe while withheld", falls - f0, 0);
        push_expect(7, 1'b1);
        gnt = 1'b1;
        repeat (70) @(negedge clk);
        check(dones - d0 == 7, "R3 saturation at seven", dones - d0, 7);
        check(falls - f0 == 7, "R3 strobes after saturation", falls - f0, 7);
        check(req == 0, "R3 request released", req, 0);

        // R6: run the row counter through its wrap
        push_expect(1016, 1'b1);
        while (sbq.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
        check(sbq.size() == 0 && model_row == 2, "R6 wrap run complete", model_row, 2);
        check(!req && !own, "R9 idle after run", {req, own}, 0);
        finish_run();
    end
endmodule